// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits on the host side of a single-rank, four-bank synchronous DRAM and drives its pulsed command lines, its multiplexed address bus and its bank-select lines. Each command is formed by the levels of the select, row-strobe, column-strobe and write-enable lines at a rising clock edge. After reset the controller holds the bus idle for a power-up interval. It then closes all banks, issues two auto refreshes and programs the mode register. No access is allowed before the mode register has been written.

A host makes one single-beat read or write at a time. It raises `req` with the direction, bank, row and column, and holds them until `ack`. The controller opens the row, issues the column command once the row-to-column delay has elapsed, and closes the row with a precharge. It acknowledges only after the precharge-to-activate delay has run out. A timer raises a refresh need once per refresh interval, which by default is 64 ms / 8192 at 100 MHz, or 781 clocks. The need is served once any access in progress has finished: the controller closes all banks and then issues an auto refresh. A request that arrives during initialization or refresh waits until the controller is idle. Only one row is ever open.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, the four command lines are all high (deselect) and `ack` is low.
- R2: After reset the lines carry NOP for exactly `INIT_WAIT` cycles. The first command (precharge-all, address bit 10 high) appears `INIT_WAIT`+1 cycles after reset release. Two auto refreshes follow, `T_RP` and then `T_RFC` cycles later, and the mode set follows `T_RFC` after the second refresh. No activate, read or write comes before the mode set.
- R3: The mode set drives the burst length code on address bits 2:0 (1→0, 2→1, 4→2, 8→3), the burst type on bit 3 (0 sequential), the CAS latency on bits 6:4, zero on all other address bits, and bank 0.
- R4: Command codes on {select, row strobe, column strobe, write}, all active low: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode set 0000. A write request produces the write code and a read request produces the read code.
- R5: An activate carries the request row on address bits 12:0 and the request bank on the bank lines.
- R6: The column command comes exactly `T_RCD` cycles after the activate, to the same bank. It carries the column on address bits 9:0 and zero on bits 12:10.
- R7: The closing precharge comes exactly `T_CPRE` cycles after the column command, with bit 10 low and the same bank. `ack` is high for exactly one cycle, `T_RP`-1 cycles after that precharge, once per request.
- R8: No activate or auto refresh comes within `T_RP` cycles of a precharge. No command other than NOP comes within `T_RFC` cycles of an auto refresh.
- R9: Once the mode register is set, one auto refresh is due every `REF_INTERVAL` cycles. It is served by a precharge-all followed `T_RP` cycles later by an auto refresh, while no row is open. The spacing between refreshes stays within a few access lengths of `REF_INTERVAL`, and the timer never expires again while a refresh is still pending.
- R10: A request raised during initialization or during a refresh is held, and its activate comes only after the mode set or after that refresh. A pending refresh is served before a waiting request.
- R11: An activate is issued only when no row is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| ack | output | 1 | One-cycle pulse when the access is complete |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_rstb_n | output | 1 | Row strobe, active low |
| mem_cstb_n | output | 1 | Column strobe, active low |
| mem_wen_n | output | 1 | Write enable, active low |
| mem_addr | output | ROW_W | Multiplexed row / column / mode address |
| mem_bank | output | BANK_W | Bank select |

## Verification
The assertions check on every cycle the spacing rules at the pins: the row-to-column gap, the precharge-to-activate and precharge-to-refresh gaps, and the quiet period after a refresh. They also check that `ack` falls the right distance after a precharge and is a single pulse, that only one row is open, that no activate comes before the mode set, and that a pending refresh is cleared before the timer expires again. Only the bench scenarios can show the exact initialization timeline, the mode word contents, and the match of row, bank, column and direction to each request. They alone show that a request raised during initialization or during a refresh is deferred correctly, and that refreshes keep arriving at the right rate over several intervals of traffic.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {select, row strobe, column strobe, write}, all active low
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } cmd_e;

  typedef enum logic [3:0] {
    S_WAIT, S_PALL, S_IREF, S_MRS, S_IDLE,
    S_ACT, S_COL, S_PRE, S_ACK, S_RPALL, S_REF
  } state_e;

  function automatic logic [2:0] burst_code(input int unsigned bl);
    case (bl)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  // low ten bits of the mode word; all higher address bits stay zero
  function automatic logic [9:0] mode_bits(input int unsigned cl,
                                           input int unsigned bl,
                                           input bit          il);
    logic [9:0] m;
    m      = '0;
    m[2:0] = burst_code(bl);
    m[3]   = il;
    m[6:4] = 3'(cl);
    return m;
  endfunction

  function automatic bit is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_INTERVAL = 781,
  parameter int MAX_WAIT     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic due
);
  localparam int CW = $clog2(REF_INTERVAL + 1);
  localparam int AW = $clog2(MAX_WAIT + 2) + 1;

  logic [CW-1:0] cnt;
  logic [AW-1:0] age;
  logic          interval_end;

  assign interval_end = en && (cnt == CW'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      if (!en || interval_end) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
      if (interval_end) due <= 1'b1;
      else if (take)    due <= 1'b0;
    end
  end

  // cycles a refresh has been pending (checker state)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (!due)      age <= '0;
    else if (age != '1) age <= age + 1'b1;
  end

  // R9
  ref_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |-> (age <= AW'(MAX_WAIT)));

  // R9
  no_missed_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interval_end |-> !due);

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_in,
  input  logic [ROW_W-1:0]  addr_in,
  input  logic [BANK_W-1:0] ba_in,
  output cmd_e              cmd_q,
  output logic [ROW_W-1:0]  addr_q,
  output logic [BANK_W-1:0] ba_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DES;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      cmd_q  <= cmd_in;
      addr_q <= addr_in;
      ba_q   <= ba_in;
    end
  end
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter int BANK_W     = 2,
  parameter int CAS_LAT    = 2,
  parameter int BURST_LEN  = 1,
  parameter bit INTERLEAVE = 1'b0,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RFC      = 7,
  parameter int T_MRD      = 2,
  parameter int T_CPRE     = 3,
  parameter int INIT_WAIT  = 100,
  parameter int INIT_REFS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              ref_due,
  output cmd_e              cmd,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic [BANK_W-1:0] cmd_ba,
  output logic              ack,
  output logic              ref_take,
  output logic              mode_set
);
  localparam int TW     = $clog2(INIT_WAIT + T_RFC + T_RCD + T_RP + T_CPRE + T_MRD + 2);
  localparam int RW     = $clog2(INIT_REFS + 1);
  localparam int AP_BIT = 10;

  state_e            state, ret_st;
  logic [TW-1:0]     timer;
  logic [RW-1:0]     iref_cnt;
  logic              lat_we;
  logic [BANK_W-1:0] lat_bank;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic              start_access;

  // load value for a command-to-command gap of d cycles (d >= 2)
  function automatic logic [TW-1:0] gap(input int unsigned d);
    return TW'(d - 2);
  endfunction

  assign start_access = (state == S_IDLE) && !ref_due && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_WAIT;
      ret_st   <= S_PALL;
      timer    <= TW'(INIT_WAIT - 1);
      iref_cnt <= '0;
      mode_set <= 1'b0;
      lat_we   <= 1'b0;
      lat_bank <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
    end else begin
      case (state)
        S_WAIT: begin
          if (timer == '0) state <= ret_st;
          else             timer <= timer - 1'b1;
        end
        S_PALL: begin
          state    <= S_WAIT;
          ret_st   <= S_IREF;
          timer    <= gap(T_RP);
          iref_cnt <= '0;
        end
        S_IREF: begin
          state    <= S_WAIT;
          timer    <= gap(T_RFC);
          iref_cnt <= iref_cnt + 1'b1;
          ret_st   <= (iref_cnt == RW'(INIT_REFS - 1)) ? S_MRS : S_IREF;
        end
        S_MRS: begin
          mode_set <= 1'b1;
          state    <= S_WAIT;
          ret_st   <= S_IDLE;
          timer    <= gap(T_MRD);
        end
        S_IDLE: begin
          if (ref_due) begin
            state <= S_RPALL;
          end else if (start_access) begin
            lat_we   <= req_we;
            lat_bank <= req_bank;
            lat_row  <= req_row;
            lat_col  <= req_col;
            state    <= S_ACT;
          end
        end
        S_ACT: begin
          state  <= S_WAIT;
          ret_st <= S_COL;
          timer  <= gap(T_RCD);
        end
        S_COL: begin
          state  <= S_WAIT;
          ret_st <= S_PRE;
          timer  <= gap(T_CPRE);
        end
        S_PRE: begin
          state  <= S_WAIT;
          ret_st <= S_ACK;
          timer  <= gap(T_RP);
        end
        S_ACK:   state <= S_IDLE;
        S_RPALL: begin
          state  <= S_WAIT;
          ret_st <= S_REF;
          timer  <= gap(T_RP);
        end
        S_REF: begin
          state  <= S_WAIT;
          ret_st <= S_IDLE;
          timer  <= gap(T_RFC);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd      = CMD_NOP;
    cmd_addr = '0;
    cmd_ba   = '0;
    ack      = 1'b0;
    ref_take = 1'b0;
    case (state)
      S_PALL: begin
        cmd              = CMD_PRE;
        cmd_addr[AP_BIT] = 1'b1;
      end
      S_RPALL: begin
        cmd              = CMD_PRE;
        cmd_addr[AP_BIT] = 1'b1;
        ref_take         = 1'b1;
      end
      S_IREF, S_REF: cmd = CMD_REF;
      S_MRS: begin
        cmd           = CMD_MRS;
        cmd_addr[9:0] = mode_bits(CAS_LAT, BURST_LEN, INTERLEAVE);
      end
      S_ACT: begin
        cmd      = CMD_ACT;
        cmd_addr = lat_row;
        cmd_ba   = lat_bank;
      end
      S_COL: begin
        cmd                  = lat_we ? CMD_WR : CMD_RD;
        cmd_addr[COL_W-1:0]  = lat_col;
        cmd_ba               = lat_bank;
      end
      S_PRE: begin
        cmd    = CMD_PRE;
        cmd_ba = lat_bank;
      end
      S_ACK: ack = 1'b1;
      default: ;
    endcase
  end

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R2
  access_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> mode_set);

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int BANK_W       = 2,
  parameter int CAS_LAT      = 2,
  parameter int BURST_LEN    = 1,
  parameter bit INTERLEAVE   = 1'b0,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_CPRE       = 3,
  parameter int INIT_WAIT    = 100,
  parameter int INIT_REFS    = 2,
  parameter int REF_INTERVAL = 781
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              ack,
  output logic              mem_sel_n,
  output logic              mem_rstb_n,
  output logic              mem_cstb_n,
  output logic              mem_wen_n,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [BANK_W-1:0] mem_bank
);
  localparam int MAX_WAIT = T_RCD + T_CPRE + T_RP + 6;
  localparam int CNT_W    = $clog2(T_RCD + T_RP + T_CPRE + T_RFC + 8) + 1;

  cmd_e              next_cmd, pin_cmd;
  logic [ROW_W-1:0]  next_addr;
  logic [BANK_W-1:0] next_ba;
  logic              ref_due, ref_take, mode_set;

  sdram_seq_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .INTERLEAVE(INTERLEAVE),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .T_CPRE(T_CPRE), .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req(req), .req_we(req_we), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col),
    .ref_due(ref_due),
    .cmd(next_cmd), .cmd_addr(next_addr), .cmd_ba(next_ba),
    .ack(ack), .ref_take(ref_take), .mode_set(mode_set)
  );

  sdram_ref_timer #(
    .REF_INTERVAL(REF_INTERVAL), .MAX_WAIT(MAX_WAIT)
  ) u_ref (
    .clk(clk), .rst_n(rst_n),
    .en(mode_set), .take(ref_take), .due(ref_due)
  );

  sdram_cmd_reg #(
    .ROW_W(ROW_W), .BANK_W(BANK_W)
  ) u_pins (
    .clk(clk), .rst_n(rst_n),
    .cmd_in(next_cmd), .addr_in(next_addr), .ba_in(next_ba),
    .cmd_q(pin_cmd), .addr_q(mem_addr), .ba_q(mem_bank)
  );

  assign {mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n} = pin_cmd;

  // ---- pin-level event trackers for the assertions ----
  logic [CNT_W-1:0] since_act, since_pre, since_ref;
  logic             row_open;
  logic             pin_act, pin_pre, pin_ref, pin_col;

  assign pin_act = (pin_cmd == CMD_ACT);
  assign pin_pre = (pin_cmd == CMD_PRE);
  assign pin_ref = (pin_cmd == CMD_REF);
  assign pin_col = is_column(pin_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      since_ref <= '1;
      row_open  <= 1'b0;
    end else begin
      if (pin_act)               since_act <= CNT_W'(1);
      else if (since_act != '1)  since_act <= since_act + 1'b1;
      if (pin_pre)               since_pre <= CNT_W'(1);
      else if (since_pre != '1)  since_pre <= since_pre + 1'b1;
      if (pin_ref)               since_ref <= CNT_W'(1);
      else if (since_ref != '1)  since_ref <= since_ref + 1'b1;
      if (pin_act)      row_open <= 1'b1;
      else if (pin_pre) row_open <= 1'b0;
    end
  end

  // R6
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_col |-> (since_act == CNT_W'(T_RCD)));

  // R8
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_act || pin_ref) |-> (since_pre >= CNT_W'(T_RP)));

  // R8
  rfc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_cmd != CMD_NOP) && (pin_cmd != CMD_DES)) |-> (since_ref >= CNT_W'(T_RFC)));

  // R7
  ack_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (since_pre == CNT_W'(T_RP - 1)));

  // R11
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_act |-> !row_open);

endmodule

// File: tb/sim_sdram_seq_ctrl.sv
module sim_sdram_seq_ctrl;
  localparam int ROW_W = 13, COL_W = 10, BANK_W = 2;
  localparam int CAS_LAT = 2, BURST_LEN = 1, INTERLEAVE = 0;
  localparam int T_RCD = 2, T_RP = 2, T_RFC = 7, T_MRD = 2, T_CPRE = 3;
  localparam int INIT_WAIT = 100, REF_INTERVAL = 781;
  localparam int SLACK = T_RFC + T_MRD + T_RCD + T_CPRE + 2 * T_RP + 8;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                         C_NOP = 4'b0111;

  logic clk, rst_n, req, req_we, ack;
  logic [BANK_W-1:0] req_bank, mem_bank;
  logic [ROW_W-1:0]  req_row, mem_addr;
  logic [COL_W-1:0]  req_col;
  logic mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n;

  sdram_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .ack(ack), .mem_sel_n(mem_sel_n), .mem_rstb_n(mem_rstb_n),
    .mem_cstb_n(mem_cstb_n), .mem_wen_n(mem_wen_n),
    .mem_addr(mem_addr), .mem_bank(mem_bank)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int nreq = 0, acks = 0, post_refs = 0, init_step = 0;
  int t_act = -1000, t_pre = -1000, t_ref = -1000, t_col = -1000, t_mrs = -1000;
  int exp_ack = -1, first_act = -1, t_req_ref = 0;
  bit mrs_seen = 0, open_row = 0, in_ref = 0, ref_req_pending = 0, done = 0;
  logic [BANK_W-1:0] open_bank;
  bit cur_we;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // behavioural responder / reference model, compared every clock
  always @(negedge clk) begin : mon
    logic [3:0] c;
    int gap;
    c = {mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n};
    if (rst_n && cyc > 0) begin
      if (ack) begin
        acks++;
        check(cyc == exp_ack, "R7", "ack cycle", cyc, exp_ack);
        exp_ack = -1;
      end
      if (c != C_NOP) begin
        check(cyc - t_ref >= T_RFC, "R8", "gap after refresh", cyc - t_ref, T_RFC);
        if (!mrs_seen) begin
          case (init_step)
            0: begin
              check(c == C_PRE && mem_addr[10], "R2", "init precharge-all", c, C_PRE);
              check(cyc == INIT_WAIT + 1, "R2", "init precharge cycle", cyc, INIT_WAIT + 1);
              t_pre = cyc;
            end
            1: begin
              check(c == C_REF, "R2", "init refresh 1", c, C_REF);
              check(cyc == t_pre + T_RP, "R2", "init refresh 1 cycle", cyc, t_pre + T_RP);
              t_ref = cyc;
            end
            2: begin
              check(c == C_REF, "R2", "init refresh 2", c, C_REF);
              check(cyc == t_ref + T_RFC, "R2", "init refresh 2 cycle", cyc, t_ref + T_RFC);
              t_ref = cyc;
            end
            default: begin
              check(c == C_MRS, "R2", "mode set code", c, C_MRS);
              check(cyc == t_ref + T_RFC, "R2", "mode set cycle", cyc, t_ref + T_RFC);
              check(mem_addr == ROW_W'((CAS_LAT << 4) | (INTERLEAVE << 3) | 0),
                    "R3", "mode word", mem_addr, (CAS_LAT << 4) | (INTERLEAVE << 3));
              check(mem_bank == 0, "R3", "mode bank", mem_bank, 0);
              mrs_seen = 1;
              t_mrs = cyc;
            end
          endcase
          init_step++;
        end else begin
          case (c)
            C_ACT: begin
              check(!open_row, "R11", "activate with row open", open_row, 0);
              check(mem_bank == cur_bank, "R5", "activate bank", mem_bank, cur_bank);
              check(mem_addr == cur_row, "R5", "activate row", mem_addr, cur_row);
              check(cyc - t_pre >= T_RP, "R8", "precharge to activate", cyc - t_pre, T_RP);
              if (ref_req_pending) begin
                check(t_ref > t_req_ref, "R10", "activate before refresh", t_ref, t_req_ref);
                ref_req_pending = 0;
              end
              if (first_act < 0) first_act = cyc;
              open_row = 1; open_bank = mem_bank; t_act = cyc;
            end
            C_RD, C_WR: begin
              check(open_row && mem_bank == open_bank, "R6", "column bank", mem_bank, open_bank);
              check(cyc - t_act == T_RCD, "R6", "activate to column", cyc - t_act, T_RCD);
              check(mem_addr[9:0] == cur_col, "R6", "column", mem_addr[9:0], cur_col);
              check(mem_addr[12:10] == 0, "R6", "column upper bits", mem_addr[12:10], 0);
              check((c == C_WR) == cur_we, "R4", "direction code", c, cur_we ? C_WR : C_RD);
              t_col = cyc;
            end
            C_PRE: begin
              if (mem_addr[10]) begin
                check(!open_row, "R9", "precharge-all with row open", open_row, 0);
                in_ref = 1;
              end else begin
                check(open_row && mem_bank == open_bank, "R7", "precharge bank", mem_bank, open_bank);
                check(cyc - t_col == T_CPRE, "R7", "column to precharge", cyc - t_col, T_CPRE);
                open_row = 0;
                exp_ack = cyc + T_RP - 1;
              end
              t_pre = cyc;
            end
            C_REF: begin
              check(in_ref && cyc - t_pre == T_RP, "R9", "precharge-all to refresh", cyc - t_pre, T_RP);
              gap = cyc - t_ref;
              check(gap <= REF_INTERVAL + SLACK && gap >= REF_INTERVAL - SLACK,
                    "R9", "refresh spacing", gap, REF_INTERVAL);
              in_ref = 0; post_refs++; t_ref = cyc;
            end
            default: check(0, "R4", "unexpected command code", c, C_NOP);
          endcase
        end
      end
    end
  end

  task automatic do_req(input bit we, input logic [BANK_W-1:0] b,
                        input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    cur_we = we; cur_bank = b; cur_row = r; cur_col = c;
    req_we = we; req_bank = b; req_row = r; req_col = c;
    req = 1'b1;
    nreq++;
    do @(negedge clk); while (!ack);
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R7", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0;
    repeat (3) @(negedge clk);
    check({mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n} == 4'b1111, "R1", "pins in reset",
          {mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n}, 4'b1111);
    check(ack == 1'b0, "R1", "ack in reset", ack, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n} == C_NOP, "R2", "NOP during power-up",
          {mem_sel_n, mem_rstb_n, mem_cstb_n, mem_wen_n}, C_NOP);
    // raised during initialization
    do_req(1'b0, 2'd0, 13'd0, 10'd0);
    check(first_act > t_mrs, "R10", "request held over init", first_act, t_mrs + 1);
    do_req(1'b1, 2'd3, 13'h1FFF, 10'h3FF);
    do_req(1'b0, 2'd1, 13'h0AAA, 10'h155);
    do_req(1'b1, 2'd2, 13'h1555, 10'h2AA);
    for (int i = 0; i < 12; i++) begin
      do_req(i[0], BANK_W'(i), ROW_W'(i * 397), COL_W'(i * 53));
      repeat (i % 3) @(negedge clk);
    end
    // raise a request while a refresh is under way
    while (!in_ref) @(negedge clk);
    t_req_ref = cyc;
    ref_req_pending = 1;
    do_req(1'b1, 2'd2, 13'h0123, 10'h0F0);
    check(ref_req_pending == 0, "R10", "deferred request served", ref_req_pending, 0);
    begin
      int k;
      k = 0;
      while (post_refs < 3) begin
        do_req(k[1], BANK_W'(k * 3), ROW_W'(k * 911), COL_W'(k * 71));
        repeat (k % 5) @(negedge clk);
        k++;
      end
    end
    repeat (20) @(negedge clk);
    check(post_refs >= 3, "R9", "refreshes seen", post_refs, 3);
    check(acks == nreq, "R7", "one ack per request", acks, nreq);
    finish_run();
  end
endmodule